// File: doc/BRIEF.md
# Eight-Way Bus Grant Priority Arbiter

This block lets eight bus-mastering devices share one processor's single request, grant and grant-acknowledge handshake. The processor sees one combined request, the OR of all device requests. When the processor answers with a bus grant, the arbiter captures the number of the highest-priority pending device. It decodes that number onto one of eight per-device grant lines and holds it until that device has taken the bus.

The arbiter also watches the address strobe, the data acknowledge and the shared grant-acknowledge line. Its `take_ok` output tells the granted device when a bus cycle boundary has been reached and no other master holds the bus. When the granted device asserts grant-acknowledge and drops its request, the arbiter picks the next-highest pending device. That device is then granted while the current master still owns the bus, so it can take over as soon as grant-acknowledge is released. If a granted device withdraws its request before acknowledging, its grant is cancelled. Nothing new is granted until the next capture event.

All ports are active-high with a synchronous, active-high reset. Inversion to active-low pins happens outside the block.

Top module: `bga_arbiter`

## Requirements
- R1: `cpu_req` is high in exactly the cycles in which at least one bit of `dev_req` is high (combinational, no delay).
- R2: At a clock edge where `cpu_grant` is high and was low at the previous edge, the arbiter captures the highest set bit position of `dev_req` (bit 7 has the highest priority, bit 0 the lowest, and the captured number is the bit position). From the following cycle the matching `dev_grant` bit is high.
- R3: A captured winner stays granted while its own request remains high and no new capture event occurs, even if higher-priority requests arrive.
- R4: At most one bit of `dev_grant` is high at any time, and it is the bit whose position equals the captured number.
- R5: After reset, and at any time when no device is captured, every `dev_grant` bit is low.
- R6: A `cpu_grant` rising edge seen while `dev_req` is all zero captures nothing, and all grants stay low.
- R7: At a clock edge where `grant_ack` is high and was low at the previous edge, the arbiter re-captures the highest remaining set bit of `dev_req`. The device that just acknowledged has already dropped its request. If no request remains, all grants go low.
- R8: If the captured device's request is low at an edge with no capture event, its grant is low from the next cycle. Requests raised afterwards receive no grant until the next `cpu_grant` or `grant_ack` rising edge.
- R9: `take_ok` is high exactly when a grant is asserted and `addr_strobe`, `data_ack` and `grant_ack` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dev_req | input | 8 | Per-device bus requests, bit 7 highest priority |
| cpu_grant | input | 1 | Bus grant from the processor |
| addr_strobe | input | 1 | Address strobe of the running bus cycle |
| data_ack | input | 1 | Data acknowledge of the running bus cycle |
| grant_ack | input | 1 | Shared grant-acknowledge, high while a device owns the bus |
| cpu_req | output | 1 | Combined bus request to the processor |
| dev_grant | output | 8 | Per-device grants, one-hot or zero |
| take_ok | output | 1 | Granted device may assert grant-acknowledge now |

## Verification
A directed sequence walks a full handover chain. It opens with a capture from a two-request pattern and a higher-priority request arriving late, which must not steal the grant. It then checks the cycle-boundary gating of `take_ok`, re-selection on two acknowledge edges, an abandoned grant with a later request that must stay ungranted, and a grant edge with no requests. Together these separate edge-triggered capture from level-sensitive re-arbitration. Seeded random toggling of every input then compares all outputs each cycle against a bench model. This exposes wrong priority order, missed or duplicated capture events, and ordering faults between abandonment and re-capture.

// File: rtl/bga_pkg.sv
package bga_pkg;
   // Default number of requesting devices.
   localparam int unsigned BGA_DEF_REQ = 8;

   // Index width needed to number N requesters.
   function automatic int unsigned bga_idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bga_prio_pick.sv
module bga_prio_pick #(
   parameter int unsigned NREQ = 8,
   parameter int unsigned IW   = 3
) (
   input  logic [NREQ-1:0] req,
   output logic [IW-1:0]   idx,
   output logic            any
);
   logic [IW-1:0] chain [NREQ];

   // Higher positions override lower ones along the chain.
   for (genvar k = 0; k < NREQ; k++) begin : g_chain
      if (k == 0) begin : g_base
         assign chain[k] = '0;
      end else begin : g_link
         assign chain[k] = req[k] ? IW'(k) : chain[k-1];
      end
   end

   assign idx = chain[NREQ-1];
   assign any = |req;
endmodule

// File: rtl/bga_onehot_dec.sv
module bga_onehot_dec #(
   parameter int unsigned NREQ = 8,
   parameter int unsigned IW   = 3
) (
   input  logic [IW-1:0]   idx,
   input  logic            en,
   output logic [NREQ-1:0] hot
);
   for (genvar k = 0; k < NREQ; k++) begin : g_dec
      assign hot[k] = en && (idx == IW'(k));
   end
endmodule

// File: rtl/bga_sel_latch.sv
module bga_sel_latch #(
   parameter int unsigned NREQ = 8,
   parameter int unsigned IW   = 3
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cpu_grant,
   input  logic            grant_ack,
   input  logic [NREQ-1:0] req,
   input  logic [IW-1:0]   pick_idx,
   input  logic            pick_any,
   output logic [IW-1:0]   sel_idx,
   output logic            sel_vld
);
   logic cg_q, ack_q;
   logic grant_rise, ack_rise, held_req;

   assign grant_rise = cpu_grant && !cg_q;
   assign ack_rise   = grant_ack && !ack_q;
   assign held_req   = req[sel_idx];

   always_ff @(posedge clk) begin
      if (rst) begin
         cg_q    <= 1'b0;
         ack_q   <= 1'b0;
         sel_idx <= '0;
         sel_vld <= 1'b0;
      end else begin
         cg_q  <= cpu_grant;
         ack_q <= grant_ack;
         if (grant_rise || ack_rise) begin
            sel_idx <= pick_idx;
            sel_vld <= pick_any;
         end else if (sel_vld && !held_req) begin
            sel_vld <= 1'b0;
         end
      end
   end

   // R2 / R7: a capture event with a pending request leaves a winner latched.
   assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (grant_rise || ack_rise) && |req |=> sel_vld);

   // R6: a capture event with no request latches nothing.
   assert_empty_capture_R6: assert property (@(posedge clk) disable iff (rst)
      (grant_rise || ack_rise) && !(|req) |=> !sel_vld);

   // R3: winner is held while its request stays and no capture occurs.
   assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      sel_vld && held_req && !grant_rise && !ack_rise |=> sel_vld && $stable(sel_idx));

   // R8: a withdrawn request loses its selection on the next cycle.
   assert_abandon_R8: assert property (@(posedge clk) disable iff (rst)
      sel_vld && !held_req && !grant_rise && !ack_rise |=> !sel_vld);

   // R8: without a capture event nothing new becomes selected.
   assert_no_spont_R8: assert property (@(posedge clk) disable iff (rst)
      !sel_vld && !grant_rise && !ack_rise |=> !sel_vld);
endmodule

// File: rtl/bga_arbiter.sv
module bga_arbiter #(
   parameter int unsigned NREQ = bga_pkg::BGA_DEF_REQ
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NREQ-1:0] dev_req,
   input  logic            cpu_grant,
   input  logic            addr_strobe,
   input  logic            data_ack,
   input  logic            grant_ack,
   output logic            cpu_req,
   output logic [NREQ-1:0] dev_grant,
   output logic            take_ok
);
   localparam int unsigned IW = bga_pkg::bga_idx_w(NREQ);

   if (NREQ < 2) begin : g_bad_cfg
      $error("bga_arbiter: NREQ must be at least 2");
   end

   logic [IW-1:0] pick_idx, sel_idx;
   logic          pick_any, sel_vld;

   bga_prio_pick #(.NREQ(NREQ), .IW(IW)) u_pick (
      .req (dev_req),
      .idx (pick_idx),
      .any (pick_any)
   );

   bga_sel_latch #(.NREQ(NREQ), .IW(IW)) u_latch (
      .clk       (clk),
      .rst       (rst),
      .cpu_grant (cpu_grant),
      .grant_ack (grant_ack),
      .req       (dev_req),
      .pick_idx  (pick_idx),
      .pick_any  (pick_any),
      .sel_idx   (sel_idx),
      .sel_vld   (sel_vld)
   );

   bga_onehot_dec #(.NREQ(NREQ), .IW(IW)) u_dec (
      .idx (sel_idx),
      .en  (sel_vld),
      .hot (dev_grant)
   );

   assign cpu_req = pick_any;
   assign take_ok = sel_vld && !addr_strobe && !data_ack && !grant_ack;

   // R4: never more than one grant line.
   assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
      $onehot0(dev_grant));

   // R9: permission to take the bus only goes with a live grant.
   assert_take_has_grant_R9: assert property (@(posedge clk) disable iff (rst)
      take_ok |-> (dev_grant != '0));

   // R5: the cycle after reset no grant is driven.
   assert_reset_quiet_R5: assert property (@(posedge clk)
      $fell(rst) |-> (dev_grant == '0));
endmodule

// File: tb/bga_arbiter_bench.sv
module bga_arbiter_bench;
   localparam int N = 8;

   logic         clk = 1'b0;
   logic         rst;
   logic [N-1:0] dev_req;
   logic         cpu_grant, addr_strobe, data_ack, grant_ack;
   logic         cpu_req, take_ok;
   logic [N-1:0] dev_grant;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 1'b0;

   // bench model state
   bit       m_vld;
   int       m_idx;
   bit       m_cg_q, m_ack_q;

   always #10 clk = ~clk; // 50 MHz

   bga_arbiter u_bga_arbiter (
      .clk(clk), .rst(rst), .dev_req(dev_req), .cpu_grant(cpu_grant),
      .addr_strobe(addr_strobe), .data_ack(data_ack), .grant_ack(grant_ack),
      .cpu_req(cpu_req), .dev_grant(dev_grant), .take_ok(take_ok)
   );

   function automatic int top_bit(input logic [N-1:0] r);
      int h = 0;
      for (int k = 0; k < N; k++) if (r[k]) h = k;
      return h;
   endfunction

   function automatic logic [N-1:0] exp_grant();
      return m_vld ? (N'(1) << m_idx) : '0;
   endfunction

   // Advance the model with the inputs present at the coming edge.
   task automatic model_edge();
      bit gr, ar;
      gr = cpu_grant && !m_cg_q;
      ar = grant_ack && !m_ack_q;
      if (rst) begin
         m_vld = 0; m_idx = 0; m_cg_q = 0; m_ack_q = 0;
      end else begin
         if (gr || ar) begin
            m_vld = |dev_req;
            m_idx = top_bit(dev_req);
         end else if (m_vld && !dev_req[m_idx]) begin
            m_vld = 0;
         end
         m_cg_q  = cpu_grant;
         m_ack_q = grant_ack;
      end
   endtask

   task automatic tick();
      model_edge();
      @(posedge clk);
      #5;
   endtask

   task automatic check(input string tag);
      logic [N-1:0] eg;
      logic         et, er;
      eg = exp_grant();
      er = |dev_req;
      et = (eg != '0) && !addr_strobe && !data_ack && !grant_ack;
      checks++;
      if (dev_grant !== eg || take_ok !== et || cpu_req !== er) begin
         errors++;
         $display("FAIL %s actual grant=%b take=%b req=%b expected grant=%b take=%b req=%b",
                  tag, dev_grant, take_ok, cpu_req, eg, et, er);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd5150));
      rst = 1; dev_req = '0; cpu_grant = 0; addr_strobe = 0; data_ack = 0; grant_ack = 0;
      m_vld = 0; m_idx = 0; m_cg_q = 0; m_ack_q = 0;
      tick(); tick();
      rst = 0;
      tick();
      check("R5 reset state");

      dev_req = 8'h12;          // devices 4 and 1
      #1 check("R1 combined request");
      tick();
      check("R5 no grant before capture");

      cpu_grant = 1; addr_strobe = 1;
      tick();
      check("R2 capture highest of 4,1");
      check("R9 take blocked by strobe");

      dev_req = 8'h92;          // device 7 arrives late
      tick();
      check("R3 late higher request ignored");
      addr_strobe = 0; data_ack = 1;
      tick();
      check("R9 take blocked by data ack");
      data_ack = 0;
      tick();
      check("R9 take allowed at boundary");

      grant_ack = 1; dev_req = 8'h82; cpu_grant = 0;  // device 4 takes bus
      tick();
      check("R7 reselect device 7");
      grant_ack = 0;             // master releases
      tick();
      check("R9 next device may take");

      grant_ack = 1; dev_req = 8'h02;                 // device 7 takes bus
      tick();
      check("R7 reselect device 1");
      dev_req = 8'h00;           // device 1 withdraws
      tick();
      check("R8 abandoned grant removed");
      dev_req = 8'h08;
      tick(); tick();
      check("R8 no grant without capture event");

      grant_ack = 0; dev_req = '0;
      tick();
      cpu_grant = 1;
      tick();
      check("R6 grant edge with no requests");
      cpu_grant = 0;
      tick();

      for (int c = 0; c < 600; c++) begin
         if ($urandom % 3 == 0) dev_req = dev_req ^ N'(1 << ($urandom % N));
         if ($urandom % 5 == 0) cpu_grant = ~cpu_grant;
         if ($urandom % 4 == 0) grant_ack = ~grant_ack;
         addr_strobe = ($urandom % 2) == 1;
         data_ack    = ($urandom % 3) == 0;
         tick();
         check("random R1 R2 R3 R4 R7 R8 R9");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule